// File: doc/BRIEF.md
# Clock-Stop SPI Master

This block drives one word at a time onto a serial link whose shift clock runs only while a word is moving and rests high between words. An active-low select frames each word. Outgoing data is launched after each falling clock edge and incoming data is captured on each rising edge, both most-significant bit first. The word length is set per transfer, from 8 to 32 bits.

The timing comes from an external divider through `bit_en`. Each `bit_en` pulse advances the link by one half bit period, so the shift clock period is two ticks. A transfer starts on a `start` strobe. Select goes low one tick before the first clock edge and stays low for a full bit period after the last rising edge. The data output is released to high impedance half a period after the last bit. When select returns high, `done` pulses and `rx_word` holds the captured word.

Top module: `spi_cs_master`

## Requirements
- R1: Out of reset and between words: `sel_n`=1, `sclk`=1, `mosi_oe`=0, `busy`=0, `done`=0.
- R2: A `start` while idle pulls `sel_n` low at the next clock edge. At that same edge `busy` and `mosi_oe` go high and `mosi` shows bit n-1 of `tx_word`. `busy` stays high until the edge that raises `done`.
- R3: The first falling edge of `sclk` comes exactly one `bit_en` tick after `sel_n` falls. Each later `sclk` edge comes one tick after the one before, giving n falling and n rising edges per word.
- R4: `mosi` changes only together with a falling edge of `sclk`. At the n rising edges it presents bits n-1 down to 0 of `tx_word`.
- R5: `miso` is sampled on each rising edge of `sclk`, first sample into bit n-1. `rx_word` holds the n sampled bits right-aligned, with the upper bits zero.
- R6: `mosi_oe` drops exactly one tick after the last rising edge of `sclk`.
- R7: `sel_n` returns high exactly two ticks (one bit period) after the last rising edge. `done` is high for exactly that one cycle, and `rx_word` is valid from that cycle on.
- R8: A `len` value below 8 acts as 8, and a value above 32 acts as 32.
- R9: A `start` while `busy` is high is ignored. The running word keeps its length and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| len | input | 6 | Word length n in bits, clamped to 8..32 |
| tx_word | input | 32 | Word to send, right-aligned |
| bit_en | input | 1 | Half bit period tick from the divider |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Shift clock, idles high |
| sel_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data to the slave |
| mosi_oe | output | 1 | Output enable for `mosi` |
| rx_word | output | 32 | Received word, right-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a word |

## Verification
A wrong phase counter shows up as a misplaced edge relative to select. The tick distance from the fall of select to the first clock edge, the count of clock edges, and the distances from the last rising edge to the output-enable drop and to the rise of select are each measured per transfer, so such an error is visible within the first word. A wrong shift register instead shows up as a corrupted received word or a wrong bit sequence at the rising edges. The bench catches this at the `done` pulse by comparing against a slave model driving a random pattern. Random divider gaps, random lengths including out-of-range values, and starts issued mid-word keep these faults from hiding behind one fixed timing.

// File: rtl/spi_cs_master.sv
module spi_cs_master #(
  parameter int MAXW = 32,
  parameter int MINW = 8,
  parameter int LW   = $clog2(MAXW + 1),
  parameter int PW   = $clog2(2 * MAXW + 3)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [LW-1:0]   len,
  input  logic [MAXW-1:0] tx_word,
  input  logic            bit_en,
  input  logic            miso,
  output logic            sclk,
  output logic            sel_n,
  output logic            mosi,
  output logic            mosi_oe,
  output logic [MAXW-1:0] rx_word,
  output logic            busy,
  output logic            done
);

  logic [LW-1:0]   len_c, len_q;
  logic [PW-1:0]   ph, ph_nx, last_rise;
  logic [MAXW-1:0] txsh, rxsh;

  always_comb begin
    if (len < LW'(MINW))      len_c = LW'(MINW);
    else if (len > LW'(MAXW)) len_c = LW'(MAXW);
    else                      len_c = len;
  end

  assign ph_nx     = ph + 1'b1;
  assign last_rise = {len_q, 1'b0};
  assign mosi      = txsh[MAXW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b1;
      sel_n   <= 1'b1;
      mosi_oe <= 1'b0;
      ph      <= '0;
      len_q   <= LW'(MINW);
      txsh    <= '0;
      rxsh    <= '0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          sel_n   <= 1'b0;
          mosi_oe <= 1'b1;
          sclk    <= 1'b1;
          ph      <= '0;
          len_q   <= len_c;
          txsh    <= tx_word << (LW'(MAXW) - len_c);
          rxsh    <= '0;
        end
      end else if (bit_en) begin
        ph <= ph_nx;
        if (ph_nx <= last_rise) begin
          if (ph_nx[0]) begin
            sclk <= 1'b0;
            if (ph_nx >= PW'(3)) txsh <= txsh << 1;
          end else begin
            sclk <= 1'b1;
            rxsh <= {rxsh[MAXW-2:0], miso};
          end
        end
        if (ph_nx == last_rise + PW'(1)) mosi_oe <= 1'b0;
        if (ph_nx == last_rise + PW'(2)) begin
          sel_n   <= 1'b1;
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_word <= rxsh;
        end
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk && sel_n && !mosi_oe)); // R1

  AST_SELECT_BEFORE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> (sclk && busy)); // R2

  AST_MOSI_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(sclk)) |-> $stable(mosi)); // R4

  AST_OE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    mosi_oe |-> !sel_n); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(len_q)); // R9

endmodule

// File: tb/spi_cs_master_test.sv
module spi_cs_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  len = 6'd8;
  logic [31:0] tx_word = '0;
  logic        bit_en = 1'b0;
  logic        miso = 1'b0;
  logic        sclk, sel_n, mosi, mosi_oe, busy, done;
  logic [31:0] rx_word;

  int checks = 0, errors = 0;
  int cyc = 0;

  spi_cs_master uut (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len), .tx_word(tx_word),
    .bit_en(bit_en), .miso(miso), .sclk(sclk), .sel_n(sel_n), .mosi(mosi),
    .mosi_oe(mosi_oe), .rx_word(rx_word), .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;

  // monitor / slave model state
  int          tk = 0, ev_sel = 0, ev_f1 = 0, ev_lr = 0, ev_oe = 0, ev_sr = 0;
  int          nfall = 0, nrise = 0, idx = 0, oe_bad = 0, cur_n = 8;
  logic [31:0] pat = '0, txcap = '0, rx_cap = '0;
  logic        got_done = 1'b0;
  logic        p_sel = 1'b1, p_sclk = 1'b1, p_oe = 1'b0;
  logic        en_gate = 1'b0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int clampn(input int l);
    if (l < 8) return 8;
    if (l > 32) return 32;
    return l;
  endfunction

  function automatic logic [31:0] maskn(input logic [31:0] v, input int n);
    if (n >= 32) return v;
    return v & ((32'd1 << n) - 32'd1);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n) begin
      if (bit_en) tk++;
      if (p_sel && !sel_n) begin
        ev_sel = tk; nfall = 0; nrise = 0; txcap = '0;
        idx = cur_n - 1; miso = pat[idx];
      end
      if (p_sclk && !sclk) begin
        if (nfall == 0) ev_f1 = tk;
        else if (idx > 0) begin idx--; miso = pat[idx]; end
        nfall++;
      end
      if (!p_sclk && sclk) begin
        ev_lr = tk; nrise++; txcap = {txcap[30:0], mosi};
        if (!mosi_oe) oe_bad++;
      end
      if (p_oe && !mosi_oe) ev_oe = tk;
      if (!p_sel && sel_n) ev_sr = tk;
      if (done) begin got_done = 1'b1; rx_cap = rx_word; end
      p_sel = sel_n; p_sclk = sclk; p_oe = mosi_oe;
      bit_en = en_gate ? 1'b1 : 1'($urandom % 2);
    end
  end

  task automatic xfer(input int l, input logic [31:0] tx, input logic [31:0] sp, input bit inject);
    int n, w;
    n = clampn(l);
    cur_n = n; pat = sp; got_done = 1'b0; oe_bad = 0;
    @(negedge clk);
    start = 1'b1; len = 6'(l); tx_word = tx;
    @(negedge clk);
    start = 1'b0;
    chk("R2 sel_n low", sel_n, 0);
    chk("R2 busy", busy, 1);
    chk("R2 mosi first bit", mosi, tx[n-1]);
    if (inject) begin
      repeat (3 + $urandom % 20) @(negedge clk);
      start = 1'b1; len = 6'(8 + $urandom % 25); tx_word = ~tx;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!got_done && w < 5000) begin @(negedge clk); w++; end
    chk("R7 done seen", got_done, 1);
    chk("R3 first fall tick", ev_f1 - ev_sel, 1);
    chk("R3 last rise tick", ev_lr - ev_sel, 2 * n);
    chk("R3 falls", nfall, n);
    chk("R3 rises", nrise, n);
    chk("R4 tx bits", maskn(txcap, n), maskn(tx, n));
    chk("R4 oe at rises", oe_bad, 0);
    chk("R5 rx word", rx_cap, maskn(sp, n));
    chk("R6 oe drop tick", ev_oe - ev_lr, 1);
    chk("R7 sel rise tick", ev_sr - ev_lr, 2);
    chk("R7 busy clear", busy, 0);
    @(negedge clk);
    chk("R7 done single", done, 0);
    chk("R1 idle", {sel_n, sclk, mosi_oe, busy}, 4'b1100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sel_n", sel_n, 1);
    chk("R1 reset sclk", sclk, 1);
    chk("R1 reset oe", mosi_oe, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    rst_n = 1'b1;
    void'($urandom(32'h5eed));
    // directed corners
    en_gate = 1'b1;
    xfer(8, 32'hA5, 32'h3C, 0);            // R3 back-to-back ticks
    en_gate = 1'b0;
    xfer(32, 32'h8000_0001, 32'hF0F0_1234, 0);
    xfer(3, 32'hFFFF_FF81, 32'hFFFF_FF7E, 0);  // R8 clamp low
    xfer(45, 32'h1357_9BDF, 32'h2468_ACE0, 0); // R8 clamp high
    xfer(12, 32'h0ABC, 32'h0555, 1);           // R9 start mid-word
    for (int i = 0; i < 25; i++)
      xfer(8 + $urandom % 25, $urandom, $urandom, ($urandom % 4) == 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule